// File: doc/BRIEF.md
# Phase-Continuous FFSK Tone Generator

This block turns a serial bit stream into a fast frequency-shift keyed waveform, delivered as one sample code per clock for an external DAC. One tone period is 140 steps of a pseudo-sine. A step divider derives the step rate from the single master clock. Every bit lasts a whole number of half tone periods, so the phase index runs on across bit boundaries without a jump. Every change of tone therefore falls on a zero crossing of the waveform.

Pins choose the data rate (1200, 2400 or 4800 baud) and the master rate (1.008 MHz or 4.032 MHz). The generator puts out a square wave at the bit rate. Its rising edge is the moment the data input is taken, and the new tone starts at the following bit boundary.

A controller with four states sequences the block:
- `ST_SLEEP` (powersave) goes to `ST_START` when the enable falls and the pins name a legal setting. It goes to `ST_BLOCK` when the setting is illegal.
- `ST_BLOCK` (illegal setting, not driving) returns to `ST_SLEEP` when the enable rises. It moves to `ST_START` once the setting becomes legal.
- `ST_START` (one cycle that clears the counters and latches the rate pins) goes to `ST_RUN`. It goes to `ST_SLEEP` if disabled and to `ST_BLOCK` if the setting is illegal.
- `ST_RUN` (driving) goes to `ST_SLEEP` on disable and to `ST_BLOCK` on an illegal setting. Any change of the rate pins sends it back to `ST_START`.

Top module: `ffsk_tx_gen`

## Requirements
- R1: The data rate is decoded from the pins as follows. `baud_slow_sel`=1 selects 1200 baud. `baud_slow_sel`=0 with `baud_fast_sel`=0 selects 2400 baud. `baud_slow_sel`=0 with `baud_fast_sel`=1 selects 4800 baud.
- R2: `xtal_hi_sel`=1 means a 4.032 MHz master and 0 means 1.008 MHz. A bit lasts master/baud clocks: 840 (1200 baud) or 420 (2400 baud) at the low rate; 3360, 1680 or 840 (1200/2400/4800 baud) at the high rate.
- R3: One table step lasts master/(tone×140) clocks. Logic 1 uses 1200 Hz at 1200 and 2400 baud and 2400 Hz at 4800 baud. Logic 0 uses 1800, 2400 and 4800 Hz at those rates. This gives 6/4/3 clocks at the low master rate, 24/16/12 at the high master rate for 1200 and 2400 baud, and 12/6 for 4800 baud.
- R4: The phase index (0..139) advances by one, modulo 140, at the end of each step and carries across bit boundaries. At the start of every bit it is 0 or 70, so the sample code there is 128.
- R5: `tx_data` is taken at the clock edge on which `tx_sync` rises. That value selects the tone of the next bit. The first bit after a start is a logic 1.
- R6: While driving, `tx_sync` is 0 for the first half of each bit (bit clock count below half the bit length) and 1 for the second half. At all other times it is 1.
- R7: When `tx_en_n` is 1 at a clock edge, the next cycle shows `drive_en`=0, `tx_sync`=1 and `sample_code`=128.
- R8: 4800 baud with the low master rate is illegal. The block then behaves as disabled (`drive_en`=0, `tx_sync`=1, code 128) until the setting becomes legal, and then starts afresh.
- R9: While driving with phase p, let h = p mod 70 and m = floor(h·(70−h)·127/1225). The code is 128+m for p<70 and 128−m otherwise. When not driving the code is 128.
- R10: After the enable falls, one start cycle with idle outputs precedes driving, which begins with phase 0 and bit clock count 0. A change of any rate pin while driving causes a new start cycle.
- R11: During and after reset, before the enable falls: `drive_en`=0, `tx_sync`=1, `sample_code`=128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_data | input | 1 | Serial data to send |
| tx_en_n | input | 1 | Transmit enable, active low; high means powersave |
| xtal_hi_sel | input | 1 | Master rate select: 1 = 4.032 MHz, 0 = 1.008 MHz |
| baud_slow_sel | input | 1 | 1 selects 1200 baud; 0 selects 2400 or 4800 |
| baud_fast_sel | input | 1 | With `baud_slow_sel`=0, 1 selects 4800 baud |
| sample_code | output | CODE_W | Pseudo-sine sample code for the DAC |
| drive_en | output | 1 | High while the DAC output is to be driven |
| tx_sync | output | 1 | Bit-rate square wave; rising edge takes `tx_data` |

## Verification
The hardest cases to reach are bit boundaries where the tone changes while the phase sits at 70 rather than 0. At such a boundary a wrong step count would leave the next bit off a zero crossing. The stimulus reaches them by changing the data at the start of every bit from a shift-register sequence, across all five legal rate settings. Runs of equal bits and alternating bits both occur, and boundaries land on both half-periods. A separate scenario reaches the illegal 4800-baud/low-master combination. It then moves to a legal setting while the enable stays low, and also changes rate pins mid-bit, which exercises the restart path.

// File: rtl/ffsk_pkg.sv
package ffsk_pkg;

    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_BLOCK = 2'd1,
        ST_START = 2'd2,
        ST_RUN   = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        BAUD_SLOW = 2'd0,
        BAUD_MID  = 2'd1,
        BAUD_FAST = 2'd2
    } baud_e;

endpackage

// File: rtl/ffsk_rate_sel.sv
module ffsk_rate_sel
    import ffsk_pkg::*;
#(
    parameter int STEPS    = 140,
    parameter int DIV_1200 = 6,
    parameter int DIV_1800 = 4,
    parameter int DIV_2400 = 3,
    parameter int PRESCALE = 4,
    parameter int BIT_W    = 12,
    parameter int DIV_W    = 5
) (
    input  baud_e              mode,
    input  logic               hi_clk,
    input  logic               mark,
    output logic [BIT_W-1:0]   bit_len,
    output logic [DIV_W-1:0]   step_div
);

    int pre_i;
    int mark_i;
    int space_i;
    int steps_i;

    always_comb begin
        pre_i = hi_clk ? PRESCALE : 1;
        case (mode)
            BAUD_SLOW: begin
                mark_i  = DIV_1200 * pre_i;
                space_i = DIV_1800 * pre_i;
                steps_i = STEPS;
            end
            BAUD_MID: begin
                mark_i  = DIV_1200 * pre_i;
                space_i = DIV_2400 * pre_i;
                steps_i = STEPS / 2;
            end
            default: begin
                mark_i  = DIV_2400 * PRESCALE;
                space_i = (DIV_2400 * PRESCALE) / 2;
                steps_i = STEPS / 2;
            end
        endcase
        bit_len  = BIT_W'(steps_i * mark_i);
        step_div = DIV_W'(mark ? mark_i : space_i);
    end

endmodule

// File: rtl/ffsk_sine_map.sv
module ffsk_sine_map #(
    parameter int STEPS  = 140,
    parameter int CODE_W = 8,
    parameter int PH_W   = 8
) (
    input  logic [PH_W-1:0]   phase,
    input  logic              active,
    output logic [CODE_W-1:0] code
);

    localparam int HALF = STEPS / 2;
    localparam int PEAK = (HALF / 2) * (HALF - HALF / 2);
    localparam int AMP  = (1 << (CODE_W - 1)) - 1;
    localparam int MID  = 1 << (CODE_W - 1);

    int ph_i;
    int h_i;
    int mag_i;

    always_comb begin
        ph_i  = int'(phase);
        h_i   = (ph_i < HALF) ? ph_i : ph_i - HALF;
        mag_i = (h_i * (HALF - h_i) * AMP) / PEAK;
        if (!active)
            code = CODE_W'(MID);
        else if (ph_i < HALF)
            code = CODE_W'(MID + mag_i);
        else
            code = CODE_W'(MID - mag_i);
    end

endmodule

// File: rtl/ffsk_tx_gen.sv
module ffsk_tx_gen
    import ffsk_pkg::*;
#(
    parameter int STEPS    = 140,
    parameter int CODE_W   = 8,
    parameter int DIV_1200 = 6,
    parameter int DIV_1800 = 4,
    parameter int DIV_2400 = 3,
    parameter int PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_data,
    input  logic              tx_en_n,
    input  logic              xtal_hi_sel,
    input  logic              baud_slow_sel,
    input  logic              baud_fast_sel,
    output logic [CODE_W-1:0] sample_code,
    output logic              drive_en,
    output logic              tx_sync
);

    localparam int HALF    = STEPS / 2;
    localparam int MAX_DIV = DIV_1200 * PRESCALE;
    localparam int MAX_BIT = STEPS * MAX_DIV;
    localparam int BIT_W   = $clog2(MAX_BIT + 1);
    localparam int DIV_W   = $clog2(MAX_DIV + 1);
    localparam int PH_W    = $clog2(STEPS);

    tx_state_e          state_q, state_d;
    baud_e              live_mode, mode_q;
    logic               hi_q;
    logic               live_legal;
    logic               cfg_moved;
    logic [BIT_W-1:0]   bit_cnt, bit_len, half_len;
    logic [DIV_W-1:0]   div_cnt, step_div;
    logic [PH_W-1:0]    phase;
    logic               cur_bit, nxt_bit;

    // live pin decode: slow select wins, fast select only when slow is low
    always_comb begin
        if (baud_slow_sel)
            live_mode = BAUD_SLOW;
        else if (baud_fast_sel)
            live_mode = BAUD_FAST;
        else
            live_mode = BAUD_MID;
        live_legal = !(live_mode == BAUD_FAST && !xtal_hi_sel);
        cfg_moved  = (live_mode != mode_q) || (xtal_hi_sel != hi_q);
    end

    ffsk_rate_sel #(
        .STEPS    (STEPS),
        .DIV_1200 (DIV_1200),
        .DIV_1800 (DIV_1800),
        .DIV_2400 (DIV_2400),
        .PRESCALE (PRESCALE),
        .BIT_W    (BIT_W),
        .DIV_W    (DIV_W)
    ) u_rate (
        .mode     (mode_q),
        .hi_clk   (hi_q),
        .mark     (cur_bit),
        .bit_len  (bit_len),
        .step_div (step_div)
    );

    assign half_len = bit_len >> 1;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SLEEP: if (!tx_en_n) state_d = live_legal ? ST_START : ST_BLOCK;
            ST_BLOCK: begin
                if (tx_en_n)         state_d = ST_SLEEP;
                else if (live_legal) state_d = ST_START;
            end
            ST_START: begin
                if (tx_en_n)          state_d = ST_SLEEP;
                else if (!live_legal) state_d = ST_BLOCK;
                else                  state_d = ST_RUN;
            end
            ST_RUN: begin
                if (tx_en_n)          state_d = ST_SLEEP;
                else if (!live_legal) state_d = ST_BLOCK;
                else if (cfg_moved)   state_d = ST_START;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SLEEP;
        else     state_q <= state_d;
    end

    // bit, step and phase counters
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            div_cnt <= '0;
            phase   <= '0;
            cur_bit <= 1'b1;
            nxt_bit <= 1'b1;
            mode_q  <= BAUD_SLOW;
            hi_q    <= 1'b0;
        end else if (state_q == ST_START) begin
            bit_cnt <= '0;
            div_cnt <= '0;
            phase   <= '0;
            cur_bit <= 1'b1;
            nxt_bit <= 1'b1;
            mode_q  <= live_mode;
            hi_q    <= xtal_hi_sel;
        end else if (state_q == ST_RUN && state_d == ST_RUN) begin
            if (bit_cnt == half_len - BIT_W'(1))
                nxt_bit <= tx_data;
            if (bit_cnt == bit_len - BIT_W'(1)) begin
                bit_cnt <= '0;
                cur_bit <= nxt_bit;
            end else begin
                bit_cnt <= bit_cnt + BIT_W'(1);
            end
            if (div_cnt == step_div - DIV_W'(1)) begin
                div_cnt <= '0;
                phase   <= (phase == PH_W'(STEPS - 1)) ? '0 : phase + PH_W'(1);
            end else begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        drive_en = (state_q == ST_RUN);
        tx_sync  = (state_q == ST_RUN) ? (bit_cnt >= half_len) : 1'b1;
    end

    ffsk_sine_map #(
        .STEPS  (STEPS),
        .CODE_W (CODE_W),
        .PH_W   (PH_W)
    ) u_sine (
        .phase  (phase),
        .active (drive_en),
        .code   (sample_code)
    );

    // R4: bit boundaries sit on a zero crossing
    a_r4_bound_phase: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && bit_cnt == '0) |-> (phase == '0 || phase == PH_W'(HALF)));

    // R4: phase moves by exactly one step, wrapping at the period
    a_r4_unit_step: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && $past(state_q) == ST_RUN && phase != $past(phase))
        |-> (phase == (($past(phase) == PH_W'(STEPS - 1)) ? '0 : PH_W'($past(phase) + PH_W'(1)))));

    // R3: the last clock of a bit is also the last clock of a step
    a_r3_div_align: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && bit_cnt == bit_len - BIT_W'(1)) |-> (div_cnt == step_div - DIV_W'(1)));

    // R5: the tone is held for the whole bit
    a_r5_bit_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && $past(state_q) == ST_RUN && bit_cnt != '0) |-> $stable(cur_bit));

    // R7: powersave releases the output on the next cycle
    a_r7_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
        tx_en_n |=> (!drive_en && tx_sync && sample_code == CODE_W'(1 << (CODE_W - 1))));

    // R8: illegal rate setting never drives
    a_r8_blocked: assert property (@(posedge clk) disable iff (rst)
        (baud_fast_sel && !baud_slow_sel && !xtal_hi_sel) |=> !drive_en);

endmodule

// File: tb/ffsk_tx_gen_bench.sv
module ffsk_tx_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_data = 1'b1;
    logic       tx_en_n = 1'b1;
    logic       xtal_hi_sel = 1'b0;
    logic       baud_slow_sel = 1'b1;
    logic       baud_fast_sel = 1'b0;
    logic [7:0] sample_code;
    logic       drive_en;
    logic       tx_sync;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_req = "R11";

    // reference model state
    int m_st = 0;      // 0 sleep, 1 blocked, 2 start, 3 run
    int m_t = 0;
    int m_phase = 0;
    int m_cur = 1;
    int m_nxt = 1;
    int m_mode = 0;    // 0 = 1200, 1 = 2400, 2 = 4800 baud
    int m_hi = 0;
    logic [7:0] lfsr = 8'hA5;

    always #2 clk = ~clk;

    ffsk_tx_gen u_ffsk_tx_gen (
        .clk           (clk),
        .rst           (rst),
        .tx_data       (tx_data),
        .tx_en_n       (tx_en_n),
        .xtal_hi_sel   (xtal_hi_sel),
        .baud_slow_sel (baud_slow_sel),
        .baud_fast_sel (baud_fast_sel),
        .sample_code   (sample_code),
        .drive_en      (drive_en),
        .tx_sync       (tx_sync)
    );

    function automatic int master_hz(input int hi);
        return (hi != 0) ? 4032000 : 1008000;
    endfunction

    function automatic int baud_hz(input int mode);
        return (mode == 0) ? 1200 : ((mode == 1) ? 2400 : 4800);
    endfunction

    function automatic int tone_hz(input int mode, input int mark);
        if (mode == 0) return (mark != 0) ? 1200 : 1800;
        if (mode == 1) return (mark != 0) ? 1200 : 2400;
        return (mark != 0) ? 2400 : 4800;
    endfunction

    function automatic int bit_clks(input int mode, input int hi);
        return master_hz(hi) / baud_hz(mode);
    endfunction

    function automatic int step_clks(input int mode, input int hi, input int mark);
        return master_hz(hi) / (tone_hz(mode, mark) * 140);
    endfunction

    function automatic int exp_code(input int p);
        int h;
        int m;
        h = p % 70;
        m = (h * (70 - h) * 127) / 1225;
        return (p < 70) ? 128 + m : 128 - m;
    endfunction

    function automatic int live_mode();
        if (baud_slow_sel) return 0;
        if (baud_fast_sel) return 2;
        return 1;
    endfunction

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    // cycle model, advanced on the same edge as the design
    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_t = 0; m_phase = 0; m_cur = 1; m_nxt = 1;
        end else begin
            int lm;
            bit legal;
            lm = live_mode();
            legal = !(lm == 2 && !xtal_hi_sel);
            case (m_st)
                0: if (!tx_en_n) m_st = legal ? 2 : 1;
                1: begin
                    if (tx_en_n) m_st = 0;
                    else if (legal) m_st = 2;
                end
                2: begin
                    if (tx_en_n) m_st = 0;
                    else if (!legal) m_st = 1;
                    else begin
                        m_st = 3; m_t = 0; m_phase = 0; m_cur = 1; m_nxt = 1;
                        m_mode = lm; m_hi = int'(xtal_hi_sel);
                    end
                end
                default: begin
                    if (tx_en_n) m_st = 0;
                    else if (!legal) m_st = 1;
                    else if (lm != m_mode || int'(xtal_hi_sel) != m_hi) m_st = 2;
                    else begin
                        int b;
                        int d;
                        b = bit_clks(m_mode, m_hi);
                        d = step_clks(m_mode, m_hi, m_cur);
                        if (m_t == b / 2 - 1) m_nxt = int'(tx_data);
                        if ((m_t + 1) % d == 0) m_phase = (m_phase + 1) % 140;
                        if (m_t == b - 1) begin
                            m_t = 0;
                            m_cur = m_nxt;
                        end else begin
                            m_t = m_t + 1;
                        end
                    end
                end
            endcase
        end
    end

    // new data at the start of every bit
    always @(negedge clk) begin
        if (!rst && m_st == 3 && m_t == 0) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            tx_data <= lfsr[0];
        end
    end

    // compare every cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            int e_code;
            int e_sync;
            int e_drv;
            if (m_st == 3) begin
                e_drv  = 1;
                e_sync = (m_t >= bit_clks(m_mode, m_hi) / 2) ? 1 : 0;
                e_code = exp_code(m_phase);
            end else begin
                e_drv = 0; e_sync = 1; e_code = 128;
            end
            chk(cur_req, "drive_en (R7)", int'(drive_en), e_drv);
            chk(cur_req, "tx_sync (R6)", int'(tx_sync), e_sync);
            chk(cur_req, "sample_code (R9)", int'(sample_code), e_code);
            if (m_st == 3 && m_t == 0)
                chk("R4", "code at bit start", int'(sample_code), 128);
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "drive_en in reset", int'(drive_en), 0);
        chk("R11", "tx_sync in reset", int'(tx_sync), 1);
        chk("R11", "sample_code in reset", int'(sample_code), 128);
        rst = 1'b0;
        wait_clks(5);
        chk("R11", "drive_en after reset", int'(drive_en), 0);
        chk("R11", "tx_sync after reset", int'(tx_sync), 1);

        // R1: low master, 1200 baud
        cur_req = "R1";
        tx_en_n = 1'b0;
        wait_clks(840 * 7 + 10);

        // R5: low master, 2400 baud (also a restart)
        cur_req = "R5";
        baud_slow_sel = 1'b0;
        wait_clks(420 * 10 + 10);

        // R2: high master, 1200 then 2400 baud
        cur_req = "R2";
        xtal_hi_sel = 1'b1;
        baud_slow_sel = 1'b1;
        wait_clks(3360 * 4 + 10);
        baud_slow_sel = 1'b0;
        wait_clks(1680 * 5 + 10);

        // R3: high master, 4800 baud
        cur_req = "R3";
        baud_fast_sel = 1'b1;
        wait_clks(840 * 8 + 10);

        // R7: powersave mid-bit, then R10 restart
        cur_req = "R7";
        tx_en_n = 1'b1;
        wait_clks(300);
        cur_req = "R10";
        tx_en_n = 1'b0;
        wait_clks(2000);

        // R8: 4800 baud with low master is blocked
        cur_req = "R8";
        xtal_hi_sel = 1'b0;
        wait_clks(1000);
        chk("R8", "drive_en while blocked", int'(drive_en), 0);
        cur_req = "R10";
        xtal_hi_sel = 1'b1;
        wait_clks(2000);

        // R4: low master 1200 baud again, mid-bit pin change
        cur_req = "R4";
        xtal_hi_sel = 1'b0;
        baud_fast_sel = 1'b0;
        baud_slow_sel = 1'b1;
        wait_clks(840 * 4 + 333);
        cur_req = "R6";
        baud_slow_sel = 1'b0;
        wait_clks(420 * 6);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog (R10): got running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule